// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block behaves as a small serial EEPROM on a two-wire open-drain bus. SCL and SDA are sampled by a much faster system clock. The block answers a select byte that carries a fixed type code and three strap-matched chip bits. It takes a two-byte memory address and stores or returns bytes from a register-based array.

Writes collect bytes in a page buffer, and the buffer is copied into the array once the master ends the transaction with STOP. Reads stream bytes from an auto-incrementing pointer that wraps across the whole array. A write-control input keeps the array unchanged by refusing the acknowledge on every data byte.

The target never drives SDA high. It only pulls the line low through `sda_oe`, and it changes that enable only while SCL is low.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A select byte is accepted and acknowledged only if bits 7..4 equal 1010 and bits 3..1 equal `chip_sel`; bit 0 is the direction (0 write, 1 read). On any other value the target gives no acknowledge and stays silent until the next START.
- R2: A byte write stores its single data byte at the addressed location after STOP. The sequence is select (write), high address byte, low address byte, data, STOP, and every byte is acknowledged.
- R3: In a page write each data byte is acknowledged and placed at the pointer, and the pointer advances by one. Only the low log2(PAGE_BYTES) address bits advance, wrapping inside the page, and the bytes reach the array after STOP.
- R4: While `wc` is 1, the select and both address bytes are still acknowledged, but no data byte is. A write transaction that has any such refused byte leaves the array unchanged.
- R5: A read returns the bytes at consecutive addresses, starting from the pointer. The pointer advances by one after each byte sent. A master acknowledge (SDA low in the 9th clock) asks for the next byte.
- R6: The read pointer wraps from address MEM_BYTES-1 to 0, and data output goes on without a break.
- R7: A read select byte that follows START directly, with no address phase, starts at the pointer value left by the previous access.
- R8: If SDA is high in the 9th clock after a read byte (no acknowledge), the target releases SDA. It drives nothing until the next START.
- R9: After reset `sda_oe` is 0. SDA is only ever pulled low, and `sda_oe` changes only while SCL is low.
- R10: A repeated START restarts select-byte reception. Data bytes not followed by a STOP are discarded, but the pointer keeps the advance they caused.
- R11: Address bits at and above log2(MEM_BYTES) are ignored, so an address is taken modulo MEM_BYTES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| wc | input | 1 | Write control; 1 refuses data bytes of writes |
| chip_sel | input | 3 | Strapped chip-enable value compared with the select byte |
| sda_oe | output | 1 | Pull-down enable for SDA (1 drives the line low) |

## Verification
Both bus lines pass through a two-flop synchronizer and an edge register, and `sda_oe` is itself registered. As a result, the enable settles about three system clocks after the SCL edge that causes it. The bench holds every SCL phase for four clocks and samples the line at least eight clocks after the falling edge that precedes it, so every acknowledge and data bit is read after it has settled. A commit to the array takes PAGE_BYTES+1 clocks after STOP is seen, so the bench idles forty clocks after each STOP before the next transfer.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } eep_state_t;

  localparam logic [3:0] EEP_TYPE_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int AW         = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_en,
  input  logic [AW-1:0] lat_addr,
  input  logic [7:0]    lat_data,
  input  logic          clear,
  input  logic          commit,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam int OW = $clog2(PAGE_BYTES);

  logic [7:0]         pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [AW-OW-1:0]   base;
  logic [OW-1:0]      idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= '0;
      busy   <= 1'b0;
      idx    <= '0;
      mem_we <= 1'b0;
      base   <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        mem_we    <= valid[idx];
        mem_waddr <= {base, idx};
        mem_wdata <= pbuf[idx];
        idx       <= idx + 1'b1;
        if (idx == OW'(PAGE_BYTES - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end else if (commit) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (clear) begin
        valid <= '0;
      end else if (lat_en) begin
        pbuf[lat_addr[OW-1:0]]  <= lat_data;
        valid[lat_addr[OW-1:0]] <= 1'b1;
        base                    <= lat_addr[AW-1:OW];
      end
    end
  end

  // R3: every array write lands inside the page last written
  assert_commit_in_page_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr[AW-1:OW] == base));
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eep_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       wc,
  input  logic [2:0] chip_sel,
  output logic       sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int OW = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  eep_state_t st;
  logic [3:0] bitcnt;
  logic in_ack, m_nack, wr_abort;
  logic [7:0] shreg, txsh, addr_hi, rdata;
  logic [AW-1:0] ptr;
  logic [15:0] full_addr;
  logic devsel_ok, active, byte_end, ack_end;
  logic buf_busy, mem_we, lat_en, commit_go, buf_clear;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata;

  eep_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_page_buf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst(rst), .lat_en(lat_en), .lat_addr(ptr), .lat_data(shreg),
    .clear(buf_clear), .commit(commit_go), .busy(buf_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eep_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata)
  );

  assign full_addr = {addr_hi, shreg};
  assign devsel_ok = (shreg[7:4] == EEP_TYPE_CODE) && (shreg[3:1] == chip_sel);
  assign active    = (st != ST_IDLE) && !start_det && !stop_det;
  assign byte_end  = active && scl_fall && !in_ack && (bitcnt == 4'd8);
  assign ack_end   = active && scl_fall && in_ack;
  assign lat_en    = byte_end && (st == ST_WDATA) && !wc;
  assign commit_go = stop_det && (st == ST_WDATA) && !wr_abort;
  assign buf_clear = start_det || (stop_det && wr_abort);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      m_nack   <= 1'b1;
      wr_abort <= 1'b0;
      sda_oe   <= 1'b0;
      shreg    <= '0;
      txsh     <= '0;
      addr_hi  <= '0;
      ptr      <= '0;
    end else if (start_det) begin
      st       <= ST_DEVSEL;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      wr_abort <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (in_ack) begin
          m_nack <= sda_s;
        end else if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (byte_end) begin
        in_ack <= 1'b1;
        case (st)
          ST_DEVSEL:  sda_oe <= devsel_ok;
          ST_ADDR_HI: begin
            sda_oe  <= 1'b1;
            addr_hi <= shreg;
          end
          ST_ADDR_LO: begin
            sda_oe <= 1'b1;
            ptr    <= full_addr[AW-1:0];
          end
          ST_WDATA: begin
            if (!wc) begin
              sda_oe         <= 1'b1;
              ptr[OW-1:0]    <= ptr[OW-1:0] + 1'b1;
            end else begin
              sda_oe   <= 1'b0;
              wr_abort <= 1'b1;
            end
          end
          ST_RDATA: begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (ack_end) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        case (st)
          ST_DEVSEL: begin
            if (!devsel_ok) begin
              st     <= ST_IDLE;
              sda_oe <= 1'b0;
            end else if (shreg[0]) begin
              st     <= ST_RDATA;
              txsh   <= rdata;
              sda_oe <= ~rdata[7];
            end else begin
              st     <= ST_ADDR_HI;
              sda_oe <= 1'b0;
            end
          end
          ST_ADDR_HI: begin
            st     <= ST_ADDR_LO;
            sda_oe <= 1'b0;
          end
          ST_ADDR_LO: begin
            st     <= ST_WDATA;
            sda_oe <= 1'b0;
          end
          ST_RDATA: begin
            if (m_nack) begin
              st     <= ST_IDLE;
              sda_oe <= 1'b0;
            end else begin
              txsh   <= rdata;
              sda_oe <= ~rdata[7];
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (scl_fall && (st == ST_RDATA)) begin
        sda_oe <= ~txsh[6];
        txsh   <= {txsh[6:0], 1'b0};
      end
    end
  end

  // R9: the pull-down enable only moves while the synchronized clock is low
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R4: a data byte closing while write control is high gets no acknowledge
  assert_wc_nack_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_end && (st == ST_WDATA) && wc) |=> !sda_oe);

  // R6: the pointer wraps to zero after the last location is sent
  assert_ptr_rollover_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_end && (st == ST_RDATA) && (&ptr)) |=> (ptr == '0));

  // R8: a missing master acknowledge returns the target to standby
  assert_nack_standby_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_end && (st == ST_RDATA) && m_nack) |=> ((st == ST_IDLE) && !sda_oe));

  // R1: a rejected select byte leaves the target in standby
  assert_devsel_reject_R1: assert property (@(posedge clk) disable iff (rst)
    (ack_end && (st == ST_DEVSEL) && !devsel_ok) |=> (st == ST_IDLE));
endmodule

// File: tb/eeprom_i2c_target_bench.sv
module eeprom_i2c_target_bench;
  localparam int MEM   = 256;
  localparam int QTR   = 4;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic wc = 1'b0;
  logic [2:0] chip_sel = 3'b101;
  logic sda_oe;
  logic sda_line;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [MEM];

  always #10 clk = ~clk;

  assign sda_line = ~(m_sda_low | sda_oe);

  eeprom_i2c_target #(.MEM_BYTES(256), .PAGE_BYTES(16)) u_eeprom_i2c_target (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .wc(wc), .chip_sel(chip_sel), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; scl = 1'b1; qw();
    m_sda_low = 1'b1; qw();
    scl = 1'b0; qw();
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; qw();
    scl = 1'b1; qw();
    m_sda_low = 1'b1; qw();
    scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qw();
    scl = 1'b1; qw();
    m_sda_low = 1'b0; qw();
    repeat (40) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; qw();
      scl = 1'b1; qw(); qw();
      scl = 1'b0; qw();
    end
    m_sda_low = 1'b0; qw();
    scl = 1'b1; qw();
    acked = (sda_line == 1'b0);
    qw();
    scl = 1'b0; qw();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw();
      scl = 1'b1; qw();
      b[i] = sda_line;
      qw();
      scl = 1'b0; qw();
    end
    m_sda_low = give_ack; qw();
    scl = 1'b1; qw(); qw();
    scl = 1'b0;
    m_sda_low = 1'b0; qw();
  endtask

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    bus_start();
    send_byte(DEV_W, a); chk(req, a, 1);
    send_byte(hi, a);    chk(req, a, 1);
    send_byte(lo, a);    chk(req, a, 1);
  endtask

  task automatic rd_check(input int a0, input int n, input string req, input bit rs);
    logic a;
    logic [7:0] b;
    if (rs) bus_rstart(); else bus_start();
    send_byte(DEV_R, a); chk(req, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i != n - 1));
      chk(req, b, model[(a0 + i) % MEM]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset", sda_oe, 0);

    // R3: fill the whole array with page writes
    for (int p = 0; p < MEM / 16; p++) begin
      addr_phase(8'h00, 8'(p * 16), "R1");
      for (int i = 0; i < 16; i++) begin
        send_byte(pat(p * 16 + i), a);
        chk("R3", a, 1);
        model[p * 16 + i] = pat(p * 16 + i);
      end
      bus_stop();
    end

    // R5/R6: sequential read across the end of the array
    addr_phase(8'h00, 8'd250, "R5");
    rd_check(250, 261, "R5/R6", 1'b1);

    // R7: current-address read continues at 255 then wraps
    rd_check(255, 2, "R7", 1'b0);

    // R2: byte write
    addr_phase(8'h00, 8'h12, "R2");
    send_byte(8'h5C, a); chk("R2", a, 1);
    bus_stop();
    model[8'h12] = 8'h5C;
    addr_phase(8'h00, 8'h11, "R2");
    rd_check(8'h11, 3, "R2", 1'b1);

    // R3: page wrap from 3E to 31
    addr_phase(8'h00, 8'h3E, "R3");
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'hD0 + i), a);
      chk("R3", a, 1);
      model[8'h30 + ((8'hE + i) % 16)] = 8'(8'hD0 + i);
    end
    bus_stop();
    addr_phase(8'h00, 8'h30, "R3");
    rd_check(8'h30, 16, "R3", 1'b1);

    // R4: write control refuses data, array unchanged
    wc = 1'b1;
    addr_phase(8'h00, 8'h50, "R4");
    send_byte(8'h11, a); chk("R4", a, 0);
    bus_stop();
    wc = 1'b0;
    addr_phase(8'h00, 8'h50, "R4");
    rd_check(8'h50, 2, "R4", 1'b1);

    // R1: wrong chip bits and wrong type code are ignored
    bus_start();
    send_byte(8'hA2, a); chk("R1", a, 0);
    send_byte(8'h00, a); chk("R1", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hBA, a); chk("R1", a, 0);
    bus_stop();

    // R8: master NACK ends the read, further clocks see a released line
    addr_phase(8'h00, 8'h20, "R8");
    bus_rstart();
    send_byte(DEV_R, a); chk("R8", a, 1);
    recv_byte(b, 1'b0); chk("R8", b, model[8'h20]);
    recv_byte(b, 1'b0); chk("R8", b, 8'hFF);
    bus_stop();

    // R10: repeated start discards pending data, pointer moved by two
    addr_phase(8'h00, 8'h70, "R10");
    send_byte(8'h99, a); chk("R10", a, 1);
    send_byte(8'h98, a); chk("R10", a, 1);
    rd_check(8'h72, 1, "R10", 1'b1);
    addr_phase(8'h00, 8'h70, "R10");
    rd_check(8'h70, 2, "R10", 1'b1);

    // R11: upper address bits ignored
    addr_phase(8'hC5, 8'h44, "R11");
    send_byte(8'hE7, a); chk("R11", a, 1);
    bus_stop();
    model[8'h44] = 8'hE7;
    addr_phase(8'h00, 8'h44, "R11");
    rd_check(8'h44, 1, "R11", 1'b1);
    chk("R9 idle", sda_oe, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule